// File: doc/BRIEF.md
# Five-channel down-counter timer bank

This block holds five down-counting timer channels behind one register window of 0x50 bytes. Software loads a count buffer per channel, then arms and starts the channel through a shared control word. Each channel counts down by one on every cycle in which its tick-enable input is high. The tick-enable inputs come from a prescaler outside the block, which also owns the two configuration words held here. When a tick arrives while a running counter holds zero, the channel raises a one-cycle expiry pulse on its own output. It then either reloads from its buffer and keeps running, or clears its own start bit and halts.

Channels 0 to 3 also keep a compare buffer, and each has an invert bit, for use by a separate waveform stage. Channel 4 has neither. Reads return data one cycle after the request. Writes take effect at the clock edge where they are presented.

Top module: `cdt_timer_bank`

## Requirements
- R1: After reset, all count buffers, compare buffers, configuration words, the interrupt word, the control word and the live counters read 0, and no expiry output is high.
- R2: The word offsets are as follows. Config words are at 0x00 and 0x04, the control word at 0x08 and the interrupt word at 0x44. For channel n = 0..4 the count buffer is at 0x0C+12n. For n = 0..3 the compare buffer is at 0x10+12n and the live-count readback is at 0x14+12n. Channel 4's readback is at 0x40. Buffers keep the low CNT_W bits of a write and read back zero-extended. Read data appears on the cycle after the read request.
- R3: In the control word, channel x uses base bit 0 for x = 0 and 4x+4 otherwise. Its start bit is at base+0, manual update at base+1, invert at base+2 and auto-reload at base+3. Bits outside this layout are not stored and read 0, so writing all ones reads back 0x007FFF0F.
- R4: A control write that takes a channel's manual-update bit from 0 to 1 copies that channel's count buffer into its counter. A write that leaves the bit at 1 does not copy.
- R5: A channel whose start bit is 1 decrements its counter by one for each tick it receives while the counter is non-zero.
- R6: A control write that clears a start bit stops that channel. Its counter then holds through later ticks.
- R7: A tick that reaches a running channel whose counter is 0 drives that channel's expiry output high for exactly the following cycle.
- R8: On expiry with auto-reload set, the counter takes the count buffer value and the start bit stays 1.
- R9: On expiry with auto-reload clear, the block clears that channel's start bit, the channel stops and the counter stays 0.
- R10: Channel 4 has no invert bit, and its auto-reload bit is control bit 22. Its start bit is bit 20 and its manual update bit is bit 21.
- R11: Reads of offsets that are not mapped, including offsets that are not word-aligned, return 0. Writes to readback offsets change nothing.
- R12: A control write in the same cycle as an expiry without auto-reload wins. The written start bit is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte offset in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| tick_en | input | 5 | Per-channel decrement enable from the prescaler |
| expire | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
The bench builds the block with CNT_W = 16 rather than the 32-bit default. A write of a 20-bit value to a count buffer then exposes the truncation and zero-extension on readback. Count values of 1 to 3 bring the zero-tick expiry, reload and self-stop paths within a handful of ticks. They also let the bench line up a control write and an expiry in the same cycle and check which one wins.

// File: rtl/cdt_pkg.sv
// Package: shared constants and control-word layout helpers for the timer bank.
// Assumes exactly five channels; the control-word layout depends on that count.
package cdt_pkg;
    localparam int NUM_CH   = 5;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int LAST_CH  = NUM_CH - 1;

    localparam logic [ADDR_W-1:0] OFF_CFG0   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG1   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_INTW   = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_LASTRD = 8'h40;

    // Base bit of a channel's group in the control word.
    function automatic int grp_base(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    function automatic int bit_start(input int ch);
        return grp_base(ch);
    endfunction

    function automatic int bit_upd(input int ch);
        return grp_base(ch) + 1;
    endfunction

    function automatic int bit_reload(input int ch);
        return (ch == LAST_CH) ? 22 : grp_base(ch) + 3;
    endfunction

    // Mask of control bits that are stored.
    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m[bit_start(c)]  = 1'b1;
            m[bit_upd(c)]    = 1'b1;
            m[bit_reload(c)] = 1'b1;
            if (c != LAST_CH) m[grp_base(c) + 2] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] off_cntbuf(input int ch);
        return ADDR_W'(8'h0C + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] off_cmpbuf(input int ch);
        return ADDR_W'(8'h10 + 12 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] off_readback(input int ch);
        return (ch == LAST_CH) ? OFF_LASTRD : ADDR_W'(8'h14 + 12 * ch);
    endfunction
endpackage

// File: rtl/cdt_channel.sv
// Module: one down-counter channel.
// Counts down on tick_i while run_i is high. On a tick at zero it pulses expire_o
// in the next cycle and either reloads from buf_i or asks the top to clear its
// start bit through stop_req_o. load_i (manual update) has priority over ticks.
module cdt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] buf_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o,
    output logic             stop_req_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             at_zero;
    logic             hit;

    assign at_zero    = (cnt_q == '0);
    assign hit        = run_i && tick_i && at_zero;
    assign stop_req_o = hit && !reload_i;
    assign cnt_o      = cnt_q;
    assign expire_o   = exp_q;

    // Counter update: manual load, else decrement or reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= hit;
            if (load_i)
                cnt_q <= buf_i;
            else if (run_i && tick_i)
                cnt_q <= at_zero ? (reload_i ? buf_i : cnt_q) : cnt_q - 1'b1;
        end
    end

    p_hold_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));
    p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !at_zero && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && reload_i && !load_i) |=> cnt_q == $past(buf_i));
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && at_zero) |=> expire_o);
endmodule

// File: rtl/cdt_rd_mux.sv
// Module: registered read multiplexer for the register window.
// Decodes the byte offset and returns the selected word one cycle after rd_i.
// Unmapped or misaligned offsets return zero.
module cdt_rd_mux
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             cfg0_i,
    input  logic [DATA_W-1:0]             cfg1_i,
    input  logic [DATA_W-1:0]             ctrl_i,
    input  logic [DATA_W-1:0]             intw_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cntbuf_i,
    input  logic [NUM_CH-2:0][CNT_W-1:0]  cmpbuf_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  live_i,
    output logic [DATA_W-1:0]             rdata_o
);
    logic [DATA_W-1:0] sel;
    logic              mapped;
    logic [DATA_W-1:0] rdata_q;

    // Offset decode into the selected word and a mapped flag.
    always_comb begin
        sel    = '0;
        mapped = 1'b1;
        unique case (addr_i)
            OFF_CFG0: sel = cfg0_i;
            OFF_CFG1: sel = cfg1_i;
            OFF_CTRL: sel = ctrl_i;
            OFF_INTW: sel = intw_i;
            default:  mapped = 1'b0;
        endcase
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr_i == off_cntbuf(c)) begin
                sel = DATA_W'(cntbuf_i[c]); mapped = 1'b1;
            end
            if (addr_i == off_readback(c)) begin
                sel = DATA_W'(live_i[c]); mapped = 1'b1;
            end
            if (c < NUM_CH - 1 && addr_i == off_cmpbuf(c)) begin
                sel = DATA_W'(cmpbuf_i[c]); mapped = 1'b1;
            end
        end
    end

    // Capture the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_i) rdata_q <= sel;
    end

    assign rdata_o = rdata_q;

    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !mapped) |=> rdata_o == '0);
endmodule

// File: rtl/cdt_timer_bank.sv
// Module: top of the five-channel down-counter timer bank.
// Holds the register file and the control word. Detects rising edges of the
// manual-update bits on control writes and clears start bits when a
// non-reloading channel expires, unless a control write happens in the same
// cycle. Assumes single-cycle wr_en/rd_en strobes and word offsets.
module cdt_timer_bank
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [4:0]        tick_en,
    output logic [4:0]        expire
);
    localparam logic [DATA_W-1:0] CMASK = ctrl_mask();

    logic [DATA_W-1:0]            cfg0_q, cfg1_q, intw_q, ctrl_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cntbuf_q;
    logic [NUM_CH-2:0][CNT_W-1:0] cmpbuf_q;
    logic [NUM_CH-1:0][CNT_W-1:0] live;
    logic [NUM_CH-1:0]            load, run, reload, stop_req;
    logic [DATA_W-1:0]            clr_mask;
    logic                         wr_ctrl;

    assign wr_ctrl = wr_en && (addr == OFF_CTRL);

    // Per-channel control decode and counter instances.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign run[g]    = ctrl_q[bit_start(g)];
        assign reload[g] = ctrl_q[bit_reload(g)];
        assign load[g]   = wr_ctrl && wdata[bit_upd(g)] && !ctrl_q[bit_upd(g)];

        cdt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[g]),
            .tick_i     (tick_en[g]),
            .run_i      (run[g]),
            .reload_i   (reload[g]),
            .buf_i      (cntbuf_q[g]),
            .cnt_o      (live[g]),
            .expire_o   (expire[g]),
            .stop_req_o (stop_req[g])
        );

        p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            load[g] |=> live[g] == $past(cntbuf_q[g]));
        p_self_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_req[g] && !wr_ctrl) |=> !ctrl_q[bit_start(g)]);
        p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_req[g] && wr_ctrl) |=> ctrl_q[bit_start(g)] == $past(wdata[bit_start(g)]));
    end

    // Start bits that self-clear this cycle.
    always_comb begin
        clr_mask = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (stop_req[c]) clr_mask[bit_start(c)] = 1'b1;
    end

    // Register file writes and control-word maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg0_q   <= '0;
            cfg1_q   <= '0;
            intw_q   <= '0;
            ctrl_q   <= '0;
            cntbuf_q <= '0;
            cmpbuf_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & CMASK;
            else         ctrl_q <= ctrl_q & ~clr_mask;
            if (wr_en) begin
                if (addr == OFF_CFG0) cfg0_q <= wdata;
                if (addr == OFF_CFG1) cfg1_q <= wdata;
                if (addr == OFF_INTW) intw_q <= wdata;
                for (int c = 0; c < NUM_CH; c++) begin
                    if (addr == off_cntbuf(c)) cntbuf_q[c] <= wdata[CNT_W-1:0];
                    if (c < NUM_CH - 1 && addr == off_cmpbuf(c))
                        cmpbuf_q[c] <= wdata[CNT_W-1:0];
                end
            end
        end
    end

    cdt_rd_mux #(.CNT_W(CNT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (rd_en),
        .addr_i   (addr),
        .cfg0_i   (cfg0_q),
        .cfg1_i   (cfg1_q),
        .ctrl_i   (ctrl_q),
        .intw_i   (intw_q),
        .cntbuf_i (cntbuf_q),
        .cmpbuf_i (cmpbuf_q),
        .live_i   (live),
        .rdata_o  (rdata)
    );

    p_ctrl_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CMASK) == '0);
endmodule

// File: tb/cdt_timer_bank_bench.sv
// Bench: scoreboard-style check of the timer bank. Read tasks push expected
// words into a queue; a monitor pops and compares them when read data is valid.
module cdt_timer_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  tick_en = '0;
    logic [4:0]  expire;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int  n_chk = 0, n_fail = 0;
    bit  rd_seen = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    cdt_timer_bank #(.CNT_W(16)) u_cdt_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .expire(expire)
    );

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare returned read data with the oldest expected item.
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input logic [4:0] m, input logic [4:0] exp_e, input string tag);
        tick_en = m;
        @(negedge clk);
        tick_en = '0;
        check({27'd0, expire}, {27'd0, exp_e}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({27'd0, expire}, 32'd0, "R1 expire after reset");
        rd(8'h08, 32'd0, "R1 control");
        rd(8'h0C, 32'd0, "R1 count buffer 0");
        rd(8'h34, 32'd0, "R1 compare buffer 3");
        rd(8'h40, 32'd0, "R1 readback 4");
        rd(8'h00, 32'd0, "R1 config0");
        // R2: map and width
        wr(8'h10, 32'h00A5); wr(8'h34, 32'h5A5A);
        wr(8'h00, 32'h1234_0101); wr(8'h04, 32'h0000_4321); wr(8'h44, 32'h0000_001F);
        wr(8'h30, 32'h000A_BCDE);
        rd(8'h10, 32'h00A5, "R2 compare 0");
        rd(8'h34, 32'h5A5A, "R2 compare 3");
        rd(8'h00, 32'h1234_0101, "R2 config0");
        rd(8'h04, 32'h0000_4321, "R2 config1");
        rd(8'h44, 32'h0000_001F, "R2 interrupt word");
        rd(8'h30, 32'h0000_BCDE, "R2 truncated count buffer 3");
        // R4/R5/R7/R9 on channel 0
        wr(8'h0C, 32'd3);
        wr(8'h08, 32'h2);
        rd(8'h14, 32'd3, "R4 manual update load");
        wr(8'h0C, 32'd9);
        wr(8'h08, 32'h3);
        rd(8'h14, 32'd3, "R4 held update bit no reload");
        tick(5'h01, 5'h00, "R5 tick 1");
        rd(8'h14, 32'd2, "R5 decrement");
        tick(5'h01, 5'h00, "R5 tick 2");
        tick(5'h01, 5'h00, "R5 tick 3");
        rd(8'h14, 32'd0, "R5 reached zero");
        tick(5'h01, 5'h01, "R7 expiry pulse");
        tick(5'h00, 5'h00, "R7 pulse is one cycle");
        rd(8'h08, 32'h2, "R9 start bit cleared");
        tick(5'h01, 5'h00, "R9 stopped no further expiry");
        rd(8'h14, 32'd0, "R9 counter stays zero");
        // R8/R6 on channel 1
        wr(8'h18, 32'd1);
        wr(8'h08, 32'h0A00);
        wr(8'h08, 32'h0B00);
        tick(5'h02, 5'h00, "R5 channel 1 tick");
        tick(5'h02, 5'h02, "R8 channel 1 expiry");
        rd(8'h20, 32'd1, "R8 reloaded value");
        rd(8'h08, 32'h0B00, "R8 start kept");
        wr(8'h08, 32'h0A00);
        tick(5'h02, 5'h00, "R6 stopped tick 1");
        tick(5'h02, 5'h00, "R6 stopped tick 2");
        rd(8'h20, 32'd1, "R6 count held");
        // R10 channel 4
        wr(8'h3C, 32'd2);
        wr(8'h08, 32'h0060_0000);
        wr(8'h08, 32'h0070_0000);
        tick(5'h10, 5'h00, "R10 tick 1");
        tick(5'h10, 5'h00, "R10 tick 2");
        tick(5'h10, 5'h10, "R10 expiry");
        rd(8'h40, 32'd2, "R10 reload via bit 22");
        rd(8'h08, 32'h0070_0000, "R10 start kept");
        // R12 channel 2: write and expiry in the same cycle
        wr(8'h08, 32'h2000);
        wr(8'h08, 32'h3000);
        wr_en = 1'b1; addr = 8'h08; wdata = 32'h3000; tick_en = 5'h04;
        @(negedge clk);
        wr_en = 1'b0; tick_en = '0;
        check({27'd0, expire}, 32'h04, "R12 expiry still pulses");
        rd(8'h08, 32'h3000, "R12 written start bit wins");
        // R11 unmapped and readback writes
        wr(8'h14, 32'hDEAD);
        rd(8'h14, 32'd0, "R11 readback write ignored");
        rd(8'h48, 32'd0, "R11 unmapped offset");
        rd(8'h0D, 32'd0, "R11 misaligned offset");
        // R3 layout mask
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h007F_FF0F, "R3 control mask");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule